// File: doc/BRIEF.md
# Vertical-Blank Flag and NMI Generator

This block keeps the raster position of a console video unit: a dot counter that steps once per video-clock enable and a scanline counter that steps when the dot counter wraps. From that position it sets a vertical-blank status flag when blanking begins and clears it on the pre-render line. When an enable bit in the control register is 1 and the flag is set, it drives an active-low NMI line to the CPU.

The CPU sees the flag in bit 7 of the status register. A status read returns the flag and then clears it. A read that falls very close to the point where the flag is set causes a race, and the block settles it in a fixed way: a read one dot before the set point hides the flag for the whole frame, and a read on the set dot or the dot after it keeps that frame's NMI from ever going low. The NMI output therefore stays high for the two dots that follow the set point, so a read in that window can still cancel it.

A write to the control register can raise the NMI or drop it while the flag is set. Reads and writes take effect only on cycles where the video-clock enable is high. The current dot and scanline are brought out for debug.

Top module: `vbl_nmi_gen`

## Requirements
- R1: The dot counter runs from 0 to DOTS-1 (default 340). When it wraps to 0 the scanline advances, and the scanline wraps from LINES-1 (default 261) to 0.
- R2: The flag becomes 1 on the enabled clock that moves the position from (VBL_LINE, SET_DOT-1) to (VBL_LINE, SET_DOT), default scanline 241 dot 1. The flag is read in bit 7 of `stat_rdata`.
- R3: On the enabled clock that moves the position onto (PRE_LINE, SET_DOT), default scanline 261 dot 1, the flag is cleared and `nmi_n` returns high.
- R4: `stat_rdata` carries the flag in bit 7 and 0 in every other bit. An enabled read clears the flag from the next clock on.
- R5: A read taken while the position is (VBL_LINE, SET_DOT-1) returns 0 in bit 7, and the flag stays 0 for the rest of that frame.
- R6: A read taken at (VBL_LINE, SET_DOT) or at (VBL_LINE, SET_DOT+1) means `nmi_n` never goes low in that frame. `nmi_n` is always high while the position is at either of those two dots.
- R7: A read two or more dots before the set point has no effect. A read at (VBL_LINE, SET_DOT+2) or later still clears the flag, but by then `nmi_n` has already been low.
- R8: `nmi_n` is low exactly when the flag is 1, control bit 7 is 1, and no race-window or dot-zero hold applies. Starting from a set flag with the enable already 1, `nmi_n` first goes low at (VBL_LINE, SET_DOT+2).
- R9: A control write with bit 7 = 0 drives `nmi_n` high on the next clock.
- R10: A control write that changes bit 7 from 0 to 1 while the flag is set drives `nmi_n` low on the next clock, unless the write falls on dot 0. A write on dot 0 keeps `nmi_n` high until the next control write or until the flag clears.
- R11: While `dot_ce` is 0, the position, the flag, the enable bit and `nmi_n` all hold, and `stat_rd` and `ctl_wr` are ignored.
- R12: Synchronous reset puts the position at scanline 0 dot 0, clears the enable bit and the flag, and drives `nmi_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dot_ce | input | 1 | Video-clock enable, one per dot |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | DATA_W | Control write data; bit EN_BIT enables the NMI |
| stat_rd | input | 1 | Status register read strobe |
| stat_rdata | output | DATA_W | Status read data; bit FLAG_BIT is the flag |
| nmi_n | output | 1 | NMI request to the CPU, active low |
| dbg_dot | output | POS_W | Current dot |
| dbg_line | output | POS_W | Current scanline |

## Verification
A wrong position count shows up on the debug outputs on the very next enabled dot. It also moves the flag's set and clear points, which shows in `stat_rdata` bit 7 within one frame. A flag or enable bit with the wrong value, or a race window in the wrong place, shows on `nmi_n` one enabled clock after the event that caused it. For that reason the scoreboard compares the position, the status byte and `nmi_n` on every clock against a model built from the requirements. Reads are placed one and two dots on each side of the set point, and control writes are placed on dot 0 and off it.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

    parameter int POS_W        = 10;
    parameter int DATA_W       = 8;
    parameter int DEF_DOTS     = 341;
    parameter int DEF_LINES    = 262;
    parameter int DEF_VBL_LINE = 241;
    parameter int DEF_PRE_LINE = 261;
    parameter int DEF_SET_DOT  = 1;
    parameter int DEF_EN_BIT   = 7;
    parameter int DEF_FLAG_BIT = 7;

    typedef logic [POS_W-1:0] coord_t;

    typedef struct packed {
        coord_t line;
        coord_t dot;
    } raster_t;

    // next-cycle view of the state that feeds the NMI driver
    typedef struct packed {
        logic flag;
        logic en;
        logic hold;
    } vbl_state_t;

    function automatic logic at_pos(raster_t p, int unsigned ln, int unsigned dt);
        return (p.line == coord_t'(ln)) && (p.dot == coord_t'(dt));
    endfunction

    function automatic raster_t step_pos(raster_t p, int unsigned dots, int unsigned lines);
        raster_t n;
        n = p;
        if (p.dot == coord_t'(dots - 1)) begin
            n.dot = '0;
            if (p.line == coord_t'(lines - 1))
                n.line = '0;
            else
                n.line = p.line + coord_t'(1);
        end else begin
            n.dot = p.dot + coord_t'(1);
        end
        return n;
    endfunction

endpackage

// File: rtl/vbl_raster_ctr.sv
module vbl_raster_ctr
    import vbl_pkg::*;
#(
    parameter int DOTS  = DEF_DOTS,
    parameter int LINES = DEF_LINES
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    dot_ce,
    output raster_t pos_q,
    output raster_t pos_nx
);

    always_comb begin
        pos_nx = dot_ce ? step_pos(pos_q, DOTS, LINES) : pos_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else
            pos_q <= pos_nx;
    end

endmodule

// File: rtl/vbl_flag.sv
module vbl_flag
    import vbl_pkg::*;
#(
    parameter int VBL_LINE = DEF_VBL_LINE,
    parameter int PRE_LINE = DEF_PRE_LINE,
    parameter int SET_DOT  = DEF_SET_DOT
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    dot_ce,
    input  raster_t pos_q,
    input  logic    rd_ev,
    output logic    flag_q,
    output logic    flag_nx
);

    localparam int PRE_SET = SET_DOT - 1;

    logic set_pt;
    logic clr_pt;

    assign set_pt = at_pos(pos_q, VBL_LINE, PRE_SET);
    assign clr_pt = at_pos(pos_q, PRE_LINE, PRE_SET);

    // a read wins over the set point: read one dot early hides the flag
    always_comb begin
        flag_nx = flag_q;
        if (dot_ce) begin
            if (rd_ev)
                flag_nx = 1'b0;
            else if (set_pt)
                flag_nx = 1'b1;
            else if (clr_pt)
                flag_nx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= flag_nx;
    end

endmodule

// File: rtl/vbl_ctl_reg.sv
module vbl_ctl_reg
    import vbl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_ev,
    input  logic   wbit,
    input  coord_t dot_q,
    input  logic   flag_q,
    input  logic   flag_nx,
    output logic   en_q,
    output logic   en_nx,
    output logic   hold_nx
);

    logic hold_q;
    logic raise_on_zero;

    assign en_nx         = wr_ev ? wbit : en_q;
    assign raise_on_zero = wbit && !en_q && flag_q && (dot_q == '0);

    always_comb begin
        if (!flag_nx)
            hold_nx = 1'b0;
        else if (wr_ev)
            hold_nx = raise_on_zero;
        else
            hold_nx = hold_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            en_q   <= en_nx;
            hold_q <= hold_nx;
        end
    end

endmodule

// File: rtl/vbl_nmi_drive.sv
module vbl_nmi_drive
    import vbl_pkg::*;
#(
    parameter int VBL_LINE = DEF_VBL_LINE,
    parameter int SET_DOT  = DEF_SET_DOT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dot_ce,
    input  raster_t    pos_nx,
    input  vbl_state_t st_nx,
    output logic       nmi_n
);

    localparam int WIN_LAST = SET_DOT + 1;

    logic in_window;

    assign in_window = at_pos(pos_nx, VBL_LINE, SET_DOT) ||
                       at_pos(pos_nx, VBL_LINE, WIN_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            nmi_n <= 1'b1;
        else if (dot_ce)
            nmi_n <= ~(st_nx.flag & st_nx.en & ~st_nx.hold & ~in_window);
    end

endmodule

// File: rtl/vbl_nmi_gen.sv
module vbl_nmi_gen
    import vbl_pkg::*;
#(
    parameter int DOTS     = DEF_DOTS,
    parameter int LINES    = DEF_LINES,
    parameter int VBL_LINE = DEF_VBL_LINE,
    parameter int PRE_LINE = DEF_PRE_LINE,
    parameter int SET_DOT  = DEF_SET_DOT,
    parameter int EN_BIT   = DEF_EN_BIT,
    parameter int FLAG_BIT = DEF_FLAG_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dot_ce,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] stat_rdata,
    output logic              nmi_n,
    output logic [POS_W-1:0]  dbg_dot,
    output logic [POS_W-1:0]  dbg_line
);

    localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << EN_BIT;

    raster_t    pos_q;
    raster_t    pos_nx;
    logic       flag_q;
    logic       flag_nx;
    logic       en_q;
    logic       en_nx;
    logic       hold_nx;
    logic       rd_ev;
    logic       wr_ev;
    vbl_state_t st_nx;
    logic [DATA_W-1:0] unused_wdata;

    assign rd_ev        = stat_rd & dot_ce;
    assign wr_ev        = ctl_wr & dot_ce;
    assign unused_wdata = ctl_wdata & ~EN_MASK;

    vbl_raster_ctr #(.DOTS(DOTS), .LINES(LINES)) ctr_i (
        .clk    (clk),
        .rst    (rst),
        .dot_ce (dot_ce),
        .pos_q  (pos_q),
        .pos_nx (pos_nx)
    );

    vbl_flag #(.VBL_LINE(VBL_LINE), .PRE_LINE(PRE_LINE), .SET_DOT(SET_DOT)) flag_i (
        .clk     (clk),
        .rst     (rst),
        .dot_ce  (dot_ce),
        .pos_q   (pos_q),
        .rd_ev   (rd_ev),
        .flag_q  (flag_q),
        .flag_nx (flag_nx)
    );

    vbl_ctl_reg ctl_i (
        .clk     (clk),
        .rst     (rst),
        .wr_ev   (wr_ev),
        .wbit    (ctl_wdata[EN_BIT]),
        .dot_q   (pos_q.dot),
        .flag_q  (flag_q),
        .flag_nx (flag_nx),
        .en_q    (en_q),
        .en_nx   (en_nx),
        .hold_nx (hold_nx)
    );

    assign st_nx = '{flag: flag_nx, en: en_nx, hold: hold_nx};

    vbl_nmi_drive #(.VBL_LINE(VBL_LINE), .SET_DOT(SET_DOT)) nmi_i (
        .clk    (clk),
        .rst    (rst),
        .dot_ce (dot_ce),
        .pos_nx (pos_nx),
        .st_nx  (st_nx),
        .nmi_n  (nmi_n)
    );

    for (genvar b = 0; b < DATA_W; b++) begin : g_stat
        if (b == FLAG_BIT) begin : g_flag
            assign stat_rdata[b] = flag_q;
        end else begin : g_zero
            assign stat_rdata[b] = 1'b0;
        end
    end

    assign dbg_dot  = pos_q.dot;
    assign dbg_line = pos_q.line;

endmodule

// File: rtl/vbl_nmi_chk.sv
module vbl_nmi_chk
    import vbl_pkg::*;
#(
    parameter int DOTS     = DEF_DOTS,
    parameter int VBL_LINE = DEF_VBL_LINE,
    parameter int PRE_LINE = DEF_PRE_LINE,
    parameter int SET_DOT  = DEF_SET_DOT,
    parameter int FLAG_BIT = DEF_FLAG_BIT
) (
    input logic              clk,
    input logic              rst,
    input logic              dot_ce,
    input logic              ctl_wr,
    input logic              ctl_en_bit,
    input logic              stat_rd,
    input logic [DATA_W-1:0] stat_rdata,
    input logic              nmi_n,
    input logic [POS_W-1:0]  dbg_dot,
    input logic [POS_W-1:0]  dbg_line
);

    localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;
    localparam int PRE_SET  = SET_DOT - 1;
    localparam int WIN_LAST = SET_DOT + 1;

    logic flag;
    assign flag = stat_rdata[FLAG_BIT];

    // R1
    dot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        dot_ce && dbg_dot == coord_t'(DOTS - 1) |=> dbg_dot == '0);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dot_ce |=> $stable(dbg_dot) && $stable(dbg_line) && $stable(nmi_n) && $stable(stat_rdata));

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        dot_ce && !stat_rd && dbg_line == coord_t'(VBL_LINE) && dbg_dot == coord_t'(PRE_SET)
        |=> flag);

    // R3
    frame_clr_chk: assert property (@(posedge clk) disable iff (rst)
        dot_ce && dbg_line == coord_t'(PRE_LINE) && dbg_dot == coord_t'(PRE_SET)
        |=> !flag && nmi_n);

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        dot_ce && stat_rd |=> !flag);

    // R4
    rd_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata & ~FLAG_MASK) == '0);

    // R6
    race_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_line == coord_t'(VBL_LINE) &&
        (dbg_dot == coord_t'(SET_DOT) || dbg_dot == coord_t'(WIN_LAST)) |-> nmi_n);

    // R8
    nmi_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !nmi_n |-> flag);

    // R9
    disable_drop_chk: assert property (@(posedge clk) disable iff (rst)
        dot_ce && ctl_wr && !ctl_en_bit |=> nmi_n);

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> dbg_dot == '0 && dbg_line == '0 && nmi_n && !flag);

endmodule

bind vbl_nmi_gen vbl_nmi_chk #(
    .DOTS     (DOTS),
    .VBL_LINE (VBL_LINE),
    .PRE_LINE (PRE_LINE),
    .SET_DOT  (SET_DOT),
    .FLAG_BIT (FLAG_BIT)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .dot_ce     (dot_ce),
    .ctl_wr     (ctl_wr),
    .ctl_en_bit (ctl_wdata[EN_BIT]),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .nmi_n      (nmi_n),
    .dbg_dot    (dbg_dot),
    .dbg_line   (dbg_line)
);

// File: tb/vbl_nmi_gen_tb_top.sv
module vbl_nmi_gen_tb_top;

    // reduced raster so that one frame is 240 dots
    localparam int DOTS  = 20;
    localparam int LINES = 12;
    localparam int VBL   = 8;
    localparam int PRE   = 11;
    localparam int SET   = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dot_ce = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       nmi_n;
    logic [9:0] dbg_dot;
    logic [9:0] dbg_line;

    always #5 clk = ~clk;   // 10 ns period, 100 MHz

    vbl_nmi_gen #(
        .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL), .PRE_LINE(PRE), .SET_DOT(SET)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .dot_ce     (dot_ce),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .stat_rd    (stat_rd),
        .stat_rdata (stat_rdata),
        .nmi_n      (nmi_n),
        .dbg_dot    (dbg_dot),
        .dbg_line   (dbg_line)
    );

    typedef struct {
        int    dot;
        int    line;
        bit    flag;
        bit    nmi_n;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    // requirement model state
    int m_dot = 0, m_line = 0;
    bit m_flag = 0, m_en = 0, m_hold = 0, m_nmi_n = 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // driver: drive one cycle, advance the model, push the expectation
    task automatic step(input bit ce, input bit rd, input bit wr, input bit wbit, input string tag);
        int  nd, nl;
        bit  f, e, h, win;
        exp_t it;
        @(negedge clk);
        dot_ce    = ce;
        stat_rd   = rd;
        ctl_wr    = wr;
        ctl_wdata = wbit ? 8'hA5 : 8'h5A;
        if (ce) begin
            nd = m_dot + 1;
            nl = m_line;
            if (nd == DOTS) begin
                nd = 0;
                nl = (m_line == LINES - 1) ? 0 : m_line + 1;
            end
            f = m_flag;
            if (rd) f = 0;
            else if (m_line == VBL && m_dot == SET - 1) f = 1;
            else if (m_line == PRE && m_dot == SET - 1) f = 0;
            e = wr ? wbit : m_en;
            if (!f) h = 0;
            else if (wr) h = wbit && !m_en && m_flag && (m_dot == 0);
            else h = m_hold;
            win = (nl == VBL) && (nd == SET || nd == SET + 1);
            m_dot = nd; m_line = nl; m_flag = f; m_en = e; m_hold = h;
            m_nmi_n = !(f && e && !h && !win);
        end
        it.dot = m_dot; it.line = m_line; it.flag = m_flag; it.nmi_n = m_nmi_n; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic run_dots(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, tag);
    endtask

    task automatic go_to(input int ln, input int dt, input string tag);
        while (!(m_line == ln && m_dot == dt)) step(1, 0, 0, 0, tag);
    endtask

    // monitor: compare just after each active edge
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                check(int'(dbg_dot) == it.dot, "R1", "dot", int'(dbg_dot), it.dot);
                check(int'(dbg_line) == it.line, "R1", "line", int'(dbg_line), it.line);
                check(stat_rdata == {it.flag, 7'b0}, it.tag, "stat_rdata",
                      int'(stat_rdata), int'({it.flag, 7'b0}));
                check(nmi_n == it.nmi_n, it.tag, "nmi_n", int'(nmi_n), int'(it.nmi_n));
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R12: reset with busy inputs
        stat_rd = 1'b1; ctl_wr = 1'b1; ctl_wdata = 8'hFF; dot_ce = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0; dot_ce = 1'b0; stat_rd = 1'b0; ctl_wr = 1'b0;
        #1;
        check(dbg_dot == '0 && dbg_line == '0, "R12", "position", int'(dbg_dot), 0);
        check(nmi_n == 1'b1, "R12", "nmi_n", int'(nmi_n), 1);
        check(stat_rdata == 8'h00, "R12", "stat_rdata", int'(stat_rdata), 0);

        // R1 R2 R3: a frame and a bit with NMI disabled
        run_dots(DOTS * LINES + 7, "R1/R2/R3 disabled");
        // R8: enable, then full frame
        step(1, 0, 1, 1, "R8 enable write");
        go_to(0, 0, "R8");
        run_dots(DOTS * LINES, "R8/R3 enabled frame");
        // R5: read one dot before the set point
        go_to(VBL, SET - 1, "R5");
        step(1, 1, 0, 0, "R5 early read");
        go_to(0, 0, "R5 frame stays clear");
        // R6: read on the set dot, then on the next dot
        go_to(VBL, SET, "R6");
        step(1, 1, 0, 0, "R6 read on set dot");
        go_to(0, 0, "R6 no nmi");
        go_to(VBL, SET + 1, "R6");
        step(1, 1, 0, 0, "R6 read after set");
        go_to(0, 0, "R6 no nmi");
        // R7: two before, and two after
        go_to(VBL - 1, DOTS - 1, "R7");
        step(1, 1, 0, 0, "R7 read two before");
        go_to(0, 0, "R7 nmi intact");
        go_to(VBL, SET + 2, "R7");
        step(1, 1, 0, 0, "R7 read two after");
        go_to(0, 0, "R7 late read");
        // R4: plain read mid-blank
        go_to(VBL + 1, 10, "R4");
        step(1, 1, 0, 0, "R4 mid read");
        go_to(0, 0, "R4");
        // R9 R10: enable changes while the flag is set
        go_to(VBL, 6, "R9");
        step(1, 0, 1, 0, "R9 disable");
        go_to(VBL + 1, 0, "R10");
        step(1, 0, 1, 1, "R10 enable on dot 0");
        run_dots(3, "R10 held");
        step(1, 0, 1, 0, "R9 disable again");
        run_dots(2, "R9");
        step(1, 0, 1, 1, "R10 enable off dot 0");
        go_to(0, 0, "R10/R3");
        // R11: stalls with strobes present while the enable is low
        for (int i = 0; i < 3 * DOTS * LINES; i++) begin
            bit ce;
            ce = ($urandom % 3) != 0;
            if (ce) step(1, 0, 0, 0, "R11");
            else    step(0, $urandom % 2, $urandom % 2, $urandom % 2, "R11 ignored");
        end
        step(1, 0, 0, 0, "R11");
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule